// File: doc/BRIEF.md
# Lockable Firmware and Timer Address Decoder

This block holds two small configuration registers and uses them to steer each incoming 32-bit memory address to one of four destinations. One destination is a high-precision timer; the other three carry the firmware (boot) region to a SPI flash path, a PCI path or an LPC path. It has a simple register port: one write strobe, one register-select bit, and a 32-bit write-data bus and read-data bus. The read data is combinational.

The firmware destination is a 2-bit field. The block loads it from two strap inputs at the moment the power-good input rises. Software may then rewrite the field until it sets a lock-down bit, and that bit stays set until reset. The timer register holds an enable bit and a 2-bit selector that picks one of four 1 KB timer windows. Any check of the firmware range that goes beyond its top-16 MB span is done elsewhere, and its result arrives as the input `fw_range_ok`.

The route flags are combinational from the address, the range-qualify input and the current register contents. At most one flag is high at a time.

Top module: `fw_timer_addr_decoder`

## Requirements
- R1: While reset is asserted and directly after it, both registers read as all zeros and no route flag is asserted.
- R2: On a cycle where `pwr_good` is high and was low at the previous clock edge, `strap_hi` loads into control bit 11 and `strap_lo` loads into control bit 10. This happens whatever the lock state is, and it wins over a software write to the same field in that cycle.
- R3: A write with `reg_sel`=1 (control register) copies write-data bits 11:10 into the destination field only if the lock bit was clear before that write. Otherwise the field keeps its value. The field encodes 00 none, 01 SPI, 10 PCI, 11 LPC.
- R4: Control bit 0 is the lock bit. Writing 1 to it sets it. Writing 0 to it has no effect. Only reset clears it.
- R5: With destination 10, every address from FF00_0000h to FFFF_FFFFh raises `rt_pci`, whatever the value of `fw_range_ok`. Addresses below that span do not raise it.
- R6: With destination 01 or 11, an address in FF00_0000h–FFFF_FFFFh raises `rt_spi` or `rt_lpc` only while `fw_range_ok` is high.
- R7: With destination 00, no firmware route flag is asserted.
- R8: A write with `reg_sel`=0 (timer register) sets the enable from bit 7 and the window select from bits 1:0. While the timer is enabled, `rt_timer` is high exactly for addresses FED0_0000h + select×1000h through that address + 3FFh.
- R9: While timer enable is 0, `rt_timer` stays low for every address.
- R10: Every control bit other than 11:10 and 0, and every timer bit other than 7 and 1:0, reads as zero and ignores writes.
- R11: At most one of `rt_timer`, `rt_spi`, `rt_pci` and `rt_lpc` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good level; its rising edge loads the straps |
| strap_hi | input | 1 | Strap level for destination bit 11 |
| strap_lo | input | 1 | Strap level for destination bit 10 |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 1 control, 0 timer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_addr | input | 32 | Memory address to decode |
| fw_range_ok | input | 1 | External qualifier for SPI and LPC firmware routing |
| rt_timer | output | 1 | Address hits the enabled timer window |
| rt_spi | output | 1 | Firmware access routed to SPI |
| rt_pci | output | 1 | Firmware access routed to PCI |
| rt_lpc | output | 1 | Firmware access routed to LPC |

## Verification
The hardest situation to reach is a power-good rising edge that meets the lock or a software write. The lock can only be cleared by reset, and the edge needs a low-to-high transition. The stimulus therefore locks the field and then drops and raises `pwr_good` with new strap values. After that it asserts reset in the middle of the run, so that it can raise `pwr_good` in the same cycle as an unlocked control write and observe which value the field takes.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   // firmware destination encoding held in the control register
   typedef enum logic [1:0] {
      DEST_NONE = 2'b00,
      DEST_SPI  = 2'b01,
      DEST_PCI  = 2'b10,
      DEST_LPC  = 2'b11
   } boot_dest_e;

   localparam int DEST_W = 2;

endpackage

// File: rtl/fwd_cfg_regs.sv
module fwd_cfg_regs
   import fwd_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int DEST_LSB   = 10,
   parameter int LOCK_BIT   = 0,
   parameter int TEN_BIT    = 7,
   parameter int TSEL_W     = 2,
   parameter bit STRAP_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_good,
   input  logic              strap_hi,
   input  logic              strap_lo,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output boot_dest_e        dest,
   output logic              lock,
   output logic              tmr_en,
   output logic [TSEL_W-1:0] tmr_sel,
   output logic              pg_rise
);

   localparam int DEST_MSB = DEST_LSB + DEST_W - 1;

   if (DEST_MSB >= DATA_W) begin : g_bad_dest
      $error("destination field does not fit the data width");
   end
   if (TEN_BIT >= DATA_W || TEN_BIT < TSEL_W) begin : g_bad_ten
      $error("timer enable bit position invalid");
   end
   if (LOCK_BIT >= DEST_LSB) begin : g_bad_lock
      $error("lock bit must sit below the destination field");
   end

   logic       pg_q;
   boot_dest_e dest_q, dest_d, dest_sw;
   logic       lock_q;
   logic       ten_q;
   logic [TSEL_W-1:0] tsel_q;
   logic       wr_ctl, wr_tmr, sw_take;
   logic       unused_wdata;

   assign unused_wdata = ^wr_data;

   assign wr_ctl  = wr_en &  wr_sel;
   assign wr_tmr  = wr_en & ~wr_sel;
   assign pg_rise = pwr_good & ~pg_q;
   assign sw_take = wr_ctl & ~lock_q;
   assign dest_sw = boot_dest_e'(wr_data[DEST_MSB:DEST_LSB]);

   if (STRAP_WINS) begin : g_strap_first
      always_comb begin
         if (pg_rise)      dest_d = boot_dest_e'({strap_hi, strap_lo});
         else if (sw_take) dest_d = dest_sw;
         else              dest_d = dest_q;
      end
   end else begin : g_sw_first
      always_comb begin
         if (sw_take)      dest_d = dest_sw;
         else if (pg_rise) dest_d = boot_dest_e'({strap_hi, strap_lo});
         else              dest_d = dest_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pg_q   <= 1'b0;
         dest_q <= DEST_NONE;
         lock_q <= 1'b0;
         ten_q  <= 1'b0;
         tsel_q <= '0;
      end else begin
         pg_q   <= pwr_good;
         dest_q <= dest_d;
         if (wr_ctl && wr_data[LOCK_BIT]) lock_q <= 1'b1;
         if (wr_tmr) begin
            ten_q  <= wr_data[TEN_BIT];
            tsel_q <= wr_data[TSEL_W-1:0];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (wr_sel) begin
         rd_data[DEST_MSB:DEST_LSB] = dest_q;
         rd_data[LOCK_BIT]          = lock_q;
      end else begin
         rd_data[TEN_BIT]           = ten_q;
         rd_data[TSEL_W-1:0]        = tsel_q;
      end
   end

   assign dest    = dest_q;
   assign lock    = lock_q;
   assign tmr_en  = ten_q;
   assign tmr_sel = tsel_q;

endmodule

// File: rtl/fwd_tmr_match.sv
module fwd_tmr_match #(
   parameter int                 ADDR_W      = 32,
   parameter int                 TSEL_W      = 2,
   parameter int                 WIN_BITS    = 10,
   parameter int                 STRIDE_BITS = 12,
   parameter logic [ADDR_W-1:0]  TMR_BASE    = ADDR_W'('hFED0_0000)
) (
   input  logic [ADDR_W-1:WIN_BITS] addr_hi,
   input  logic                     en,
   input  logic [TSEL_W-1:0]        sel,
   output logic                     hit
);

   localparam int NWIN = 1 << TSEL_W;

   if (STRIDE_BITS < WIN_BITS) begin : g_bad_stride
      $error("window stride smaller than window size");
   end
   if (STRIDE_BITS + TSEL_W > ADDR_W) begin : g_bad_span
      $error("timer windows exceed the address space");
   end

   logic [NWIN-1:0] win_hit;

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      localparam logic [ADDR_W-1:0] WBASE = TMR_BASE + (ADDR_W'(w) << STRIDE_BITS);
      assign win_hit[w] = (addr_hi == WBASE[ADDR_W-1:WIN_BITS]);
   end

   assign hit = en & win_hit[sel];

endmodule

// File: rtl/fwd_fw_route.sv
module fwd_fw_route
   import fwd_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int REGION_BITS = 24
) (
   input  logic [ADDR_W-1:REGION_BITS] addr_hi,
   input  boot_dest_e                  dest,
   input  logic                        range_ok,
   input  logic                        block,
   output logic                        to_spi,
   output logic                        to_pci,
   output logic                        to_lpc
);

   logic in_region;
   logic live;

   assign in_region = &addr_hi;
   assign live      = in_region & ~block;

   always_comb begin
      to_spi = 1'b0;
      to_pci = 1'b0;
      to_lpc = 1'b0;
      unique case (dest)
         DEST_PCI:  to_pci = live;
         DEST_SPI:  to_spi = live & range_ok;
         DEST_LPC:  to_lpc = live & range_ok;
         default:   ;
      endcase
   end

endmodule

// File: rtl/fw_timer_addr_decoder.sv
module fw_timer_addr_decoder
   import fwd_pkg::*;
#(
   parameter int                ADDR_W      = 32,
   parameter int                DATA_W      = 32,
   parameter int                REGION_BITS = 24,
   parameter int                WIN_BITS    = 10,
   parameter int                STRIDE_BITS = 12,
   parameter int                TSEL_W      = 2,
   parameter logic [ADDR_W-1:0] TMR_BASE    = ADDR_W'('hFED0_0000),
   parameter bit                STRAP_WINS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_good,
   input  logic              strap_hi,
   input  logic              strap_lo,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic              fw_range_ok,
   output logic              rt_timer,
   output logic              rt_spi,
   output logic              rt_pci,
   output logic              rt_lpc
);

   localparam int DEST_LSB = 10;
   localparam int LOCK_BIT = 0;
   localparam int TEN_BIT  = 7;

   if (REGION_BITS >= ADDR_W || WIN_BITS >= REGION_BITS) begin : g_bad_region
      $error("region or window size inconsistent with address width");
   end
   if (&TMR_BASE[ADDR_W-1:REGION_BITS]) begin : g_tmr_overlap
      $error("timer base lies inside the firmware region");
   end

   boot_dest_e        dest_w;
   logic              lock_w;
   logic              ten_w;
   logic [TSEL_W-1:0] tsel_w;
   logic              pg_rise_w;
   logic              tmr_hit;
   logic              unused_addr_lo;

   assign unused_addr_lo = ^mem_addr[WIN_BITS-1:0];

   fwd_cfg_regs #(
      .DATA_W    (DATA_W),
      .DEST_LSB  (DEST_LSB),
      .LOCK_BIT  (LOCK_BIT),
      .TEN_BIT   (TEN_BIT),
      .TSEL_W    (TSEL_W),
      .STRAP_WINS(STRAP_WINS)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwr_good(pwr_good),
      .strap_hi(strap_hi),
      .strap_lo(strap_lo),
      .wr_en   (reg_wr),
      .wr_sel  (reg_sel),
      .wr_data (reg_wdata),
      .rd_data (reg_rdata),
      .dest    (dest_w),
      .lock    (lock_w),
      .tmr_en  (ten_w),
      .tmr_sel (tsel_w),
      .pg_rise (pg_rise_w)
   );

   fwd_tmr_match #(
      .ADDR_W     (ADDR_W),
      .TSEL_W     (TSEL_W),
      .WIN_BITS   (WIN_BITS),
      .STRIDE_BITS(STRIDE_BITS),
      .TMR_BASE   (TMR_BASE)
   ) u_tmr (
      .addr_hi(mem_addr[ADDR_W-1:WIN_BITS]),
      .en     (ten_w),
      .sel    (tsel_w),
      .hit    (tmr_hit)
   );

   fwd_fw_route #(
      .ADDR_W     (ADDR_W),
      .REGION_BITS(REGION_BITS)
   ) u_fw (
      .addr_hi (mem_addr[ADDR_W-1:REGION_BITS]),
      .dest    (dest_w),
      .range_ok(fw_range_ok),
      .block   (tmr_hit),
      .to_spi  (rt_spi),
      .to_pci  (rt_pci),
      .to_lpc  (rt_lpc)
   );

   assign rt_timer = tmr_hit;

endmodule

// File: rtl/fw_timer_addr_decoder_chk.sv
module fw_timer_addr_decoder_chk #(
   parameter int ADDR_W      = 32,
   parameter int REGION_BITS = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strap_hi,
   input logic              strap_lo,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              fw_range_ok,
   input logic [1:0]        dest,
   input logic              lock,
   input logic              tmr_en,
   input logic              pg_rise,
   input logic              rt_timer,
   input logic              rt_spi,
   input logic              rt_pci,
   input logic              rt_lpc
);

   // R2
   strap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pg_rise |=> dest == $past({strap_hi, strap_lo}));

   // R3
   locked_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !pg_rise) |=> $stable(dest));

   // R4
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> lock);

   // R5
   pci_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dest == 2'b10 && (&mem_addr[ADDR_W-1:REGION_BITS])) |-> rt_pci);

   // R6
   spi_qualify_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rt_spi || rt_lpc) |-> fw_range_ok);

   // R7
   none_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dest == 2'b00) |-> !(rt_spi || rt_pci || rt_lpc));

   // R9
   tmr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_en |-> !rt_timer);

   // R11
   route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rt_timer, rt_spi, rt_pci, rt_lpc}));

endmodule

bind fw_timer_addr_decoder fw_timer_addr_decoder_chk #(
   .ADDR_W     (ADDR_W),
   .REGION_BITS(REGION_BITS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .strap_hi   (strap_hi),
   .strap_lo   (strap_lo),
   .mem_addr   (mem_addr),
   .fw_range_ok(fw_range_ok),
   .dest       (dest_w),
   .lock       (lock_w),
   .tmr_en     (ten_w),
   .pg_rise    (pg_rise_w),
   .rt_timer   (rt_timer),
   .rt_spi     (rt_spi),
   .rt_pci     (rt_pci),
   .rt_lpc     (rt_lpc)
);

// File: tb/fw_timer_addr_decoder_tb.sv
module fw_timer_addr_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_good = 1'b0;
   logic        strap_hi = 1'b0;
   logic        strap_lo = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] mem_addr = '0;
   logic        fw_range_ok = 1'b0;
   logic [31:0] reg_rdata;
   logic        rt_timer, rt_spi, rt_pci, rt_lpc;

   fw_timer_addr_decoder u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_good   (pwr_good),
      .strap_hi   (strap_hi),
      .strap_lo   (strap_lo),
      .reg_wr     (reg_wr),
      .reg_sel    (reg_sel),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .mem_addr   (mem_addr),
      .fw_range_ok(fw_range_ok),
      .rt_timer   (rt_timer),
      .rt_spi     (rt_spi),
      .rt_pci     (rt_pci),
      .rt_lpc     (rt_lpc)
   );

   always #10 clk = ~clk;

   // behavioural reference state
   int unsigned m_dest = 0;
   int unsigned m_sel  = 0;
   bit          m_lock = 0;
   bit          m_en   = 0;
   bit          m_pgq  = 0;
   bit          m_rise = 0;

   int    checks = 0;
   int    errors = 0;
   int    cyc    = 0;
   bit    done   = 0;
   string cur_req = "R1";

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_dest = 0; m_sel = 0; m_lock = 0; m_en = 0; m_pgq = 0;
      end else begin
         m_rise = pwr_good && !m_pgq;
         m_pgq  = pwr_good;
         if (reg_wr && reg_sel) begin
            if (!m_lock) m_dest = reg_wdata[11:10];
            if (reg_wdata[0]) m_lock = 1;
         end
         if (reg_wr && !reg_sel) begin
            m_en  = reg_wdata[7];
            m_sel = reg_wdata[1:0];
         end
         if (m_rise) m_dest = {strap_hi, strap_lo};
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      #5;
      if (!done) begin
         logic [31:0] exp_rd;
         logic        in_fw, e_t, e_s, e_p, e_l;
         if (reg_sel) exp_rd = (m_dest << 10) | 32'(m_lock);
         else         exp_rd = (32'(m_en) << 7) | m_sel;
         in_fw = (mem_addr[31:24] == 8'hFF);
         e_t = m_en && ((mem_addr & 32'hFFFF_FC00) == (32'hFED0_0000 | (m_sel << 12)));
         e_p = in_fw && m_dest == 2;
         e_s = in_fw && m_dest == 1 && fw_range_ok;
         e_l = in_fw && m_dest == 3 && fw_range_ok;
         chk(cur_req, reg_rdata, exp_rd);
         chk(cur_req, {28'b0, rt_timer, rt_spi, rt_pci, rt_lpc}, {28'b0, e_t, e_s, e_p, e_l});
         chk("R11", 32'($countones({rt_timer, rt_spi, rt_pci, rt_lpc}) <= 1), 32'd1);
      end
   end

   task automatic step(input logic wr, input logic sel, input logic [31:0] wd,
                       input logic [31:0] a, input logic ok);
      @(negedge clk);
      #1;
      reg_wr = wr; reg_sel = sel; reg_wdata = wd; mem_addr = a; fw_range_ok = ok;
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000 && !done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected<=5000", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      // R1 reset state
      cur_req = "R1";
      step(0, 1, 0, 32'hFF00_0000, 1);
      step(0, 0, 0, 32'hFED0_0000, 1);
      step(0, 1, 0, 32'hFFFF_FFFF, 1);
      rst_n = 1'b1;
      step(0, 0, 0, 32'hFF00_0000, 1);
      step(0, 1, 0, 32'hFF00_0000, 1);

      // R2 strap capture on power-good rise: 10 -> PCI
      cur_req = "R2";
      strap_hi = 1'b1; strap_lo = 1'b0; pwr_good = 1'b1;
      step(0, 1, 0, 32'h0000_1000, 0);
      step(0, 1, 0, 32'hFF00_0000, 0);

      // R5 PCI region regardless of qualifier
      cur_req = "R5";
      step(0, 1, 0, 32'hFFFF_FFFF, 0);
      step(0, 1, 0, 32'hFEFF_FFFF, 1);
      step(0, 1, 0, 32'hFF12_3456, 1);

      // R3 software rewrites the field while unlocked: 01 -> SPI
      cur_req = "R3";
      step(1, 1, 32'h0000_0400, 32'h0, 0);
      step(0, 1, 0, 32'hFF80_0000, 0);
      // R6 SPI needs the qualifier
      cur_req = "R6";
      step(0, 1, 0, 32'hFF80_0000, 1);
      step(1, 1, 32'h0000_0C00, 32'h0, 0);
      step(0, 1, 0, 32'hFFC0_0000, 0);
      step(0, 1, 0, 32'hFFC0_0000, 1);

      // R7 destination none
      cur_req = "R7";
      step(1, 1, 32'h0000_0000, 32'h0, 0);
      step(0, 1, 0, 32'hFFFF_0000, 1);
      step(0, 1, 0, 32'hFF00_0000, 0);

      // R10 reserved bits read zero
      cur_req = "R10";
      step(1, 1, 32'hFFFF_F3FE, 32'h0, 0);
      step(0, 1, 0, 32'h0, 0);
      step(1, 0, 32'hFFFF_FF7C, 32'h0, 0);
      step(0, 0, 0, 32'hFED0_0000, 0);

      // R8 each timer window, its edges and a neighbour
      cur_req = "R8";
      for (int s = 0; s < 4; s++) begin
         logic [31:0] base;
         base = 32'hFED0_0000 + (32'(s) << 12);
         step(1, 0, 32'h80 | 32'(s), 32'h0, 0);
         step(0, 0, 0, base, 0);
         step(0, 0, 0, base + 32'h3FF, 1);
         step(0, 0, 0, base + 32'h400, 0);
         step(0, 0, 0, base ^ 32'h1000, 0);
      end

      // R9 timer disabled
      cur_req = "R9";
      step(1, 0, 32'h0000_0003, 32'h0, 0);
      step(0, 0, 0, 32'hFED0_3000, 0);
      step(0, 0, 0, 32'hFED0_33FF, 1);

      // R4 lock: set PCI, lock, then attempt changes
      cur_req = "R4";
      step(1, 1, 32'h0000_0800, 32'h0, 0);
      step(1, 1, 32'h0000_0001, 32'h0, 0);
      step(1, 1, 32'h0000_0C00, 32'h0, 0);
      step(1, 1, 32'h0000_0000, 32'hFF00_0000, 0);
      step(0, 1, 0, 32'hFF00_0000, 0);
      cur_req = "R3";
      step(1, 1, 32'h0000_0400, 32'hFFFF_FFFF, 0);
      step(0, 1, 0, 32'hFFFF_FFFF, 1);

      // R2 straps still load while locked: 01 -> SPI
      cur_req = "R2";
      pwr_good = 1'b0;
      step(0, 1, 0, 32'h0, 0);
      strap_hi = 1'b0; strap_lo = 1'b1; pwr_good = 1'b1;
      step(0, 1, 0, 32'hFF00_0000, 1);
      step(0, 1, 0, 32'hFF00_0000, 1);
      step(0, 1, 0, 32'hFF00_0000, 0);

      // R4 reset clears the lock; R2 strap beats simultaneous write
      cur_req = "R4";
      rst_n = 1'b0; pwr_good = 1'b0;
      step(0, 1, 0, 32'h0, 0);
      rst_n = 1'b1;
      step(0, 1, 0, 32'h0, 0);
      cur_req = "R2";
      strap_hi = 1'b1; strap_lo = 1'b1; pwr_good = 1'b1;
      step(1, 1, 32'h0000_0400, 32'hFF00_0000, 1);
      step(0, 1, 0, 32'hFF00_0000, 1);
      step(0, 1, 0, 32'hFF00_0000, 0);
      step(0, 0, 0, 32'hFF00_0000, 0);

      @(negedge clk);
      #8;
      done = 1;
      summary();
      $finish;
   end

endmodule